// File: doc/BRIEF.md
# Synchronous FIFO Queue with Flag Registers

This block is a single-clock first-in-first-out queue. It sits between a producer and a consumer so that either side can work in bursts. The producer pulses a write strobe with a data word. The consumer sees the oldest unread word at the output at all times and pulses a read strobe to remove it. Registered full and empty outputs tell each side when it must stop. An optional half-full output reports when the queue holds at least half its depth.

Storage is a two-port array. It is written on the clock edge and read combinationally at the read pointer. The read pointer and the write pointer are plain binary counters that wrap at the power-of-two depth. Equal pointers can mean either an empty queue or a full one. The block resolves this with two flag flip-flops rather than an extra pointer bit. These flags are updated from the accepted operations and from an equality test on the pointer values after the operation.

Top module: `sync_flag_fifo`

## Requirements
- R1: While rst_n is low and in the first cycle after it is released, empty is 1, full is 0 and half_full is 0.
- R2: rd_data always shows the oldest word that has been written and not yet read. Words leave in the order they were written.
- R3: An accepted write with no accepted read sets full and clears empty if the pointers are equal after it. Otherwise it clears both flags. The flags change on the clock edge of the write.
- R4: An accepted read with no accepted write sets empty and clears full if the pointers are equal after it. Otherwise it clears both flags.
- R5: The full and empty flags hold their values in a cycle with no accepted operation, and in a cycle where a write and a read are both accepted.
- R6: A write while full, without a read in the same cycle, is ignored. The stored words, their order and the flags stay unchanged.
- R7: A read while empty is ignored and the read pointer does not move. The next word written is the next word read.
- R8: half_full is 1 exactly when occupancy is at least DEPTH/2. Occupancy is the write pointer minus the read pointer modulo DEPTH, or DEPTH when full is set. With HALF_EN = 0 the output is held at 0.
- R9: When full, a write and a read in the same cycle are both accepted and the queue stays full. When empty, a write and a read in the same cycle accept only the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to enqueue |
| rd_en | input | 1 | Read strobe; pops the word shown on rd_data |
| rd_data | output | DATA_W | Oldest unread word (combinational from the array) |
| full | output | 1 | Registered full flag |
| empty | output | 1 | Registered empty flag |
| half_full | output | 1 | Occupancy at least half the depth |

## Verification
The full and empty flags, and half_full, change one clock edge after the strobes that cause them. rd_data follows the read pointer with no further delay, so the word just written or the next word appears right after that same edge. The bench drives its strobes on the falling edge and keeps a reference queue that it updates at the rising edge. It compares every output at the following falling edge, so each result is sampled in the first cycle it is due. Directed sequences hit the full and empty boundaries and the simultaneous read and write cases. Seeded random traffic covers the rest.

// File: rtl/fifo_pkg.sv
// Shared types for the flag-register FIFO.
// Assumes nothing beyond IEEE 1800-2017 packages.
package fifo_pkg;

    // Operation accepted by the queue in one cycle, after the full/empty gating
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_e;

endpackage

// File: rtl/fifo_ptr.sv
// Binary wrapping pointer with count enable.
// Shows both the registered value and the value it takes at the next edge.
// Assumes the depth is 2**PTR_W, so natural overflow gives the wrap.
module fifo_ptr #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] ptr_nxt
);

    // Next pointer value: increment when the operation is accepted
    always_comb begin
        ptr_nxt = adv ? ptr_q + PTR_W'(1) : ptr_q;
    end

    // Pointer register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_nxt;
    end

endmodule

// File: rtl/fifo_store.sv
// Two-port storage array: synchronous write port, combinational read port.
// Assumes the write address is only driven with an accepted write.
// Contents are not reset.
module fifo_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Write port: store the word on the clock edge
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Read port: combinational look-up at the read address
    always_comb begin
        rdata = mem_q[raddr];
    end

endmodule

// File: rtl/fifo_flag_ctl.sv
// Full/empty flag state machine.
// Inputs are the accepted operation and whether the pointers will be equal
// after it. A lone push can only make the pointers meet when full; a lone
// pop can only make them meet when empty; anything else holds the flags.
module fifo_flag_ctl
    import fifo_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  fifo_op_e op,
    input  logic     ptr_eq_nxt,
    output logic     full_q,
    output logic     empty_q
);

    logic full_d;
    logic empty_d;

    // Truth table for next flag values
    always_comb begin
        full_d  = full_q;
        empty_d = empty_q;
        case (op)
            OP_PUSH: begin
                full_d  = ptr_eq_nxt;
                empty_d = 1'b0;
            end
            OP_POP: begin
                full_d  = 1'b0;
                empty_d = ptr_eq_nxt;
            end
            default: begin
                full_d  = full_q;
                empty_d = empty_q;
            end
        endcase
    end

    // Flag registers; reset lands in the empty state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            full_q  <= full_d;
            empty_q <= empty_d;
        end
    end

endmodule

// File: rtl/sync_flag_fifo.sv
// Single-clock FIFO queue with registered full and empty flags.
// Gating: a pop needs a non-empty queue; a push needs room or a same-cycle pop.
// Assumes DEPTH = 2**ADDR_W (ADDR_W >= 1). HALF_EN selects the half-full output.
module sync_flag_fifo
    import fifo_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    parameter bit HALF_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic              half_full
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int OCC_W = ADDR_W + 1;

    logic              push_ok;
    logic              pop_ok;
    fifo_op_e          op;
    logic [ADDR_W-1:0] wptr_q, wptr_nxt;
    logic [ADDR_W-1:0] rptr_q, rptr_nxt;
    logic              full_q, empty_q;

    // Accept strobes only when the queue state allows them
    always_comb begin
        pop_ok  = rd_en && !empty_q;
        push_ok = wr_en && (!full_q || pop_ok);
        op      = fifo_op_e'({push_ok, pop_ok});
    end

    fifo_ptr #(.PTR_W(ADDR_W)) u_wptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (push_ok),
        .ptr_q   (wptr_q),
        .ptr_nxt (wptr_nxt)
    );

    fifo_ptr #(.PTR_W(ADDR_W)) u_rptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (pop_ok),
        .ptr_q   (rptr_q),
        .ptr_nxt (rptr_nxt)
    );

    fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (push_ok),
        .waddr (wptr_q),
        .wdata (wr_data),
        .raddr (rptr_q),
        .rdata (rd_data)
    );

    fifo_flag_ctl u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .ptr_eq_nxt (wptr_nxt == rptr_nxt),
        .full_q     (full_q),
        .empty_q    (empty_q)
    );

    // Flags leave the block straight from their registers
    always_comb begin
        full  = full_q;
        empty = empty_q;
    end

    generate
        if (HALF_EN) begin : g_half
            logic [OCC_W-1:0] occ;
            // Occupancy from the pointer difference; the full flag supplies DEPTH
            always_comb begin
                occ       = full_q ? OCC_W'(DEPTH) : {1'b0, wptr_q - rptr_q};
                half_full = occ >= OCC_W'(DEPTH / 2);
            end
        end else begin : g_no_half
            // Half-full indication not built
            always_comb begin
                half_full = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/fifo_flag_chk.sv
// Checker for the flag behaviour of sync_flag_fifo, attached by bind.
module fifo_flag_chk #(
    parameter bit HALF_EN = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic rd_en,
    input logic full,
    input logic empty,
    input logic half_full
);

    // R3 R4
    never_full_and_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R3
    push_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !full) |=> !empty);

    // R4
    pop_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !empty) |=> !full);

    // R5
    idle_holds_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en) |=> ($stable(full) && $stable(empty)));

    // R6
    push_on_full_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> full);

    // R7
    pop_on_empty_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> empty);

    // R9
    both_on_full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && rd_en) |=> full);

    generate
        if (HALF_EN) begin : g_half_chk
            // R8
            full_implies_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
                full |-> half_full);
            // R8
            empty_not_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
                empty |-> !half_full);
        end
    endgenerate

endmodule

bind sync_flag_fifo fifo_flag_chk #(.HALF_EN(HALF_EN)) u_flag_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .full      (full),
    .empty     (empty),
    .half_full (half_full)
);

// File: tb/sync_flag_fifo_tb_top.sv
`timescale 1ns/1ps
module sync_flag_fifo_tb_top;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              full, empty, half_full;

    int n_chk = 0;
    int n_bad = 0;
    logic [DATA_W-1:0] model_q[$];

    always #2.5 clk = ~clk;

    sync_flag_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .HALF_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty),
        .half_full(half_full)
    );

    function automatic bit exp_half(int sz);
        return sz >= DEPTH / 2;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare all outputs with the reference queue (called at a falling edge)
    task automatic check_all(string tag);
        check(tag, "empty", empty, model_q.size() == 0);
        check(tag, "full", full, model_q.size() == DEPTH);
        check("R8", "half_full", half_full, exp_half(model_q.size()));
        if (model_q.size() > 0) check("R2", "rd_data", rd_data, model_q[0]);
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge
    task automatic step(bit w, bit r, logic [DATA_W-1:0] d, string tag_in);
        bit pop_ok, push_ok;
        string tag;
        wr_en = w; rd_en = r; wr_data = d;
        pop_ok  = r && model_q.size() > 0;
        push_ok = w && (model_q.size() < DEPTH || pop_ok);
        @(posedge clk);
        if (pop_ok)  void'(model_q.pop_front());
        if (push_ok) model_q.push_back(d);
        @(negedge clk);
        if (tag_in != "") tag = tag_in;
        else if (push_ok && !pop_ok) tag = "R3";
        else if (pop_ok && !push_ok) tag = "R4";
        else tag = "R5";
        check_all(tag);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20240607);
        repeat (3) @(negedge clk);
        // R1: reset state during and right after reset
        check("R1", "empty in reset", empty, 1);
        check("R1", "full in reset", full, 0);
        check("R1", "half in reset", half_full, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "empty after reset", empty, 1);
        check("R1", "full after reset", full, 0);

        // R7: reads on an empty queue do nothing
        step(1'b0, 1'b1, 8'h00, "R7");
        step(1'b0, 1'b1, 8'h00, "R7");
        step(1'b1, 1'b0, 8'hA5, "R7");
        check("R7", "first word after empty reads", rd_data, 8'hA5);
        step(1'b0, 1'b1, 8'h00, "R4");

        // R9: write and read together on an empty queue: write only
        step(1'b1, 1'b1, 8'h3C, "R9");
        check("R9", "word kept", rd_data, 8'h3C);
        step(1'b0, 1'b1, 8'h00, "R4");

        // R3: fill to the top
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 8'(i * 7 + 1), "");
        check("R3", "full at depth", full, 1);

        // R6: writes on a full queue are ignored
        step(1'b1, 1'b0, 8'hEE, "R6");
        step(1'b1, 1'b0, 8'hEF, "R6");

        // R9: write and read together on a full queue
        step(1'b1, 1'b1, 8'h77, "R9");
        check("R9", "still full", full, 1);

        // R4 R2: drain in order
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 8'h00, "");
        check("R4", "empty after drain", empty, 1);

        // R5: idle cycles hold flags
        step(1'b0, 1'b0, 8'h11, "R5");

        // Random traffic with biased mixes
        for (int ph = 0; ph < 3; ph++) begin
            for (int k = 0; k < 1500; k++) begin
                int wp;
                wp = (ph == 0) ? 70 : (ph == 1) ? 30 : 50;
                step(($urandom % 100) < wp, ($urandom % 100) < (100 - wp),
                     8'($urandom), "");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule